// File: doc/BRIEF.md
# Column-Associative Read Cache

This block is a direct-mapped read cache that gives conflicting lines a second home. The line array is split into two halves. Every address has a home slot, its ordinary index, and a buddy slot, which is the same index with its most significant bit inverted. A lookup probes the home slot first. On a miss it may probe the buddy slot as well. A per-line relocation flag marks lines that sit in their buddy slot rather than their home slot. A found or fetched line is always moved to its home slot. Any line that has to make room is pushed to the buddy slot and gets its relocation flag set.

A requester presents an address with `req_valid` while `req_ready` is high. One response cycle later or more, `rsp_valid` rises with the data word and a result kind. On a miss the block issues a one-word fill to the next level through a request pulse, and it takes the reply when `mem_rsp_valid` arrives. Three event counters record first-probe hits, second-probe hits and misses.

The controller is one state machine with six states. IDLE accepts a request (IDLE→LOOK1). LOOK1 probes the home slot. Its exits are a hit (LOOK1→IDLE), a miss at a relocated home slot (LOOK1→FILL) and any other miss (LOOK1→LOOK2). LOOK2 probes the buddy slot, with a hit going to LOOK2→SWAP and a miss to LOOK2→FILL. SWAP exchanges the two slots (SWAP→IDLE). FILL raises the memory request (FILL→WAIT). WAIT holds until the reply arrives (WAIT→IDLE).

Top module: `cac_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and all three counters read 0. Every line is invalid with its relocation flag clear, so the first access to any address is a miss.
- R2: A first-probe hit is one whose tag matches at the home slot `addr[IDX_W-1:0]`. It responds in the first cycle after acceptance with `rsp_kind` = 2'b01 and the cached word. `req_ready` is high again in the following cycle.
- R3: On a first-probe miss where the home slot's relocation flag is set, no second probe is made. The fill request is raised in the second cycle after acceptance. The fetched line overwrites the home slot and has its flag cleared, and nothing is moved to the buddy slot.
- R4: On a first-probe miss where the home flag is clear, the buddy slot is probed. The buddy slot is the home index with bit IDX_W-1 inverted. A tag match there responds in the second cycle after acceptance with `rsp_kind` = 2'b10 and the cached word.
- R5: A second-probe hit is followed by one swap cycle in which `req_ready` stays low. After the swap, the found line sits in its home slot with its flag clear. The former home occupant sits in the buddy slot with its flag set. As a result, the pattern a,b,c,b,c,… with a and b sharing a home slot and c in the buddy slot gives first-probe hits for every access after the first three.
- R6: On a second-probe miss, a fill is issued in the third cycle after acceptance. When the reply arrives, the fetched line is written to the home slot with its flag clear. The former home occupant moves to the buddy slot, and its flag is set if it was valid. The old buddy content is dropped.
- R7: A fill raises `mem_req_valid` for exactly one cycle with `mem_req_addr` equal to the requested address. The response is given in the cycle where `mem_rsp_valid` is high, with `rsp_kind` = 2'b11 and `rsp_data` = `mem_rsp_data`.
- R8: `req_ready` is low from the cycle after acceptance until the cycle after the response, and it also stays low during a swap.
- R9: Each response increments exactly one counter. `cnt_hit` counts kind 01, `cnt_hit2` counts kind 10 and `cnt_miss` counts kind 11. All three wrap modulo 2^CNT_W.
- R10: The stored tag is `addr[ADDR_W-1:IDX_W-1]`. It includes the top index bit, so a line sitting in its buddy slot never matches a first probe for a different address, and the returned data always belongs to the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address of the read |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 01 first hit, 10 second hit, 11 miss, 00 idle |
| rsp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | One-cycle fill request to next level |
| mem_req_addr | output | ADDR_W | Fill address |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_data | input | DATA_W | Fill data |
| cnt_hit | output | CNT_W | First-probe hit count |
| cnt_hit2 | output | CNT_W | Second-probe hit count |
| cnt_miss | output | CNT_W | Miss count |

## Verification
The directed part of the test first drives the a,b,c,b,c pattern. This confirms that the relocation flag prevents the ping-pong between the two halves: every access after warm-up must be a first-probe hit. A second directed pair shares one home slot and is read alternately. This pattern separates second-probe hits with a swap from fills, and it ends with an access whose home slot is relocated, which tells the skipped-probe miss (latency 4) apart from a full double-probe miss (latency 5). A seeded random stream then draws from four tags on two buddy index pairs. It keeps both halves in constant conflict, and a bench model of slot contents predicts the kind, latency and data of every response.

// File: rtl/cac_pkg.sv
package cac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK1,
        ST_LOOK2,
        ST_SWAP,
        ST_FILL,
        ST_WAIT
    } cac_state_e;

    localparam logic [1:0] KIND_NONE = 2'b00;
    localparam logic [1:0] KIND_HIT  = 2'b01;
    localparam logic [1:0] KIND_HIT2 = 2'b10;
    localparam logic [1:0] KIND_MISS = 2'b11;

endpackage

// File: rtl/cac_line_array.sv
module cac_line_array #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_vld,
    output logic              ra_reh,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_dat,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_vld,
    output logic              rb_reh,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_dat,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic              wa_vld,
    input  logic              wa_reh,
    input  logic [TAG_W-1:0]  wa_tag,
    input  logic [DATA_W-1:0] wa_dat,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic              wb_vld,
    input  logic              wb_reh,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_dat
);

    localparam int LINES = 1 << IDX_W;
    localparam int ENT_W = 2 + TAG_W + DATA_W;

    logic [ENT_W-1:0] ent_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (wa_en && wa_idx == IDX_W'(i))
                    ent_q[i] <= {wa_vld, wa_reh, wa_tag, wa_dat};
                else if (wb_en && wb_idx == IDX_W'(i))
                    ent_q[i] <= {wb_vld, wb_reh, wb_tag, wb_dat};
            end
        end
    end

    assign {ra_vld, ra_reh, ra_tag, ra_dat} = ent_q[ra_idx];
    assign {rb_vld, rb_reh, rb_tag, rb_dat} = ent_q[rb_idx];

endmodule

// File: rtl/cac_event_counters.sv
module cac_event_counters #(
    parameter int N_EV  = 3,
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_EV-1:0]             inc,
    output logic [N_EV-1:0][CNT_W-1:0]  cnt
);

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        logic [CNT_W-1:0] c_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      c_q <= '0;
            else if (inc[g]) c_q <= c_q + CNT_W'(1);
        end
        assign cnt[g] = c_q;
    end

endmodule

// File: rtl/cac_cache.sv
module cac_cache
    import cac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_hit2,
    output logic [CNT_W-1:0]  cnt_miss
);

    localparam int TAG_W = ADDR_W - IDX_W + 1;
    localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(1) << (IDX_W - 1);

    cac_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              probed2_q;

    logic [IDX_W-1:0] idx_home, idx_buddy;
    logic [TAG_W-1:0] tag_req;

    assign idx_home  = addr_q[IDX_W-1:0];
    assign idx_buddy = idx_home ^ TOP_BIT;
    assign tag_req   = addr_q[ADDR_W-1:IDX_W-1];

    logic              a_vld, a_reh, b_vld, b_reh;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_dat, b_dat;
    logic              wa_en, wa_vld, wa_reh, wb_en, wb_vld, wb_reh;
    logic [TAG_W-1:0]  wa_tag, wb_tag;
    logic [DATA_W-1:0] wa_dat, wb_dat;

    cac_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (idx_home),
        .ra_vld (a_vld),
        .ra_reh (a_reh),
        .ra_tag (a_tag),
        .ra_dat (a_dat),
        .rb_idx (idx_buddy),
        .rb_vld (b_vld),
        .rb_reh (b_reh),
        .rb_tag (b_tag),
        .rb_dat (b_dat),
        .wa_en  (wa_en),
        .wa_idx (idx_home),
        .wa_vld (wa_vld),
        .wa_reh (wa_reh),
        .wa_tag (wa_tag),
        .wa_dat (wa_dat),
        .wb_en  (wb_en),
        .wb_idx (idx_buddy),
        .wb_vld (wb_vld),
        .wb_reh (wb_reh),
        .wb_tag (wb_tag),
        .wb_dat (wb_dat)
    );

    logic hit_a, hit_b;
    assign hit_a = a_vld && (a_tag == tag_req);
    assign hit_b = b_vld && (b_tag == tag_req);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            probed2_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) addr_q <= req_addr;
            if (state_q == ST_LOOK1) probed2_q <= 1'b0;
            if (state_q == ST_LOOK2) probed2_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_LOOK1;
            ST_LOOK1: begin
                if (hit_a)      state_d = ST_IDLE;
                else if (a_reh) state_d = ST_FILL;
                else            state_d = ST_LOOK2;
            end
            ST_LOOK2: state_d = hit_b ? ST_SWAP : ST_FILL;
            ST_SWAP:  state_d = ST_IDLE;
            ST_FILL:  state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and array writes
    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        rsp_kind      = KIND_NONE;
        rsp_data      = '0;
        mem_req_valid = 1'b0;
        wa_en  = 1'b0; wa_vld = 1'b0; wa_reh = 1'b0; wa_tag = '0; wa_dat = '0;
        wb_en  = 1'b0; wb_vld = 1'b0; wb_reh = 1'b0; wb_tag = '0; wb_dat = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_LOOK1: if (hit_a) begin
                rsp_valid = 1'b1;
                rsp_kind  = KIND_HIT;
                rsp_data  = a_dat;
            end
            ST_LOOK2: if (hit_b) begin
                rsp_valid = 1'b1;
                rsp_kind  = KIND_HIT2;
                rsp_data  = b_dat;
            end
            ST_SWAP: begin
                wa_en = 1'b1; wa_vld = b_vld; wa_reh = 1'b0;  wa_tag = b_tag; wa_dat = b_dat;
                wb_en = 1'b1; wb_vld = a_vld; wb_reh = a_vld; wb_tag = a_tag; wb_dat = a_dat;
            end
            ST_FILL:  mem_req_valid = 1'b1;
            ST_WAIT:  if (mem_rsp_valid) begin
                rsp_valid = 1'b1;
                rsp_kind  = KIND_MISS;
                rsp_data  = mem_rsp_data;
                wa_en = 1'b1; wa_vld = 1'b1; wa_reh = 1'b0; wa_tag = tag_req; wa_dat = mem_rsp_data;
                if (probed2_q) begin
                    wb_en = 1'b1; wb_vld = a_vld; wb_reh = a_vld; wb_tag = a_tag; wb_dat = a_dat;
                end
            end
            default: ;
        endcase
    end

    assign mem_req_addr = addr_q;

    logic [2:0]             ev_inc;
    logic [2:0][CNT_W-1:0]  ev_cnt;
    assign ev_inc[0] = rsp_valid && (rsp_kind == KIND_HIT);
    assign ev_inc[1] = rsp_valid && (rsp_kind == KIND_HIT2);
    assign ev_inc[2] = rsp_valid && (rsp_kind == KIND_MISS);

    cac_event_counters #(.N_EV(3), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ev_inc),
        .cnt   (ev_cnt)
    );

    assign cnt_hit  = ev_cnt[0];
    assign cnt_hit2 = ev_cnt[1];
    assign cnt_miss = ev_cnt[2];

    AST_REH_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOK1 && !hit_a && a_reh) |=> (state_q == ST_FILL)); // R3
    AST_BUDDY_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOK1 && !hit_a && !a_reh) |=> (state_q == ST_LOOK2)); // R4
    AST_SWAP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_HIT2) |=> !req_ready); // R5
    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R7
    AST_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_FILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R8
    AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_HIT) |=> cnt_hit == $past(cnt_hit) + CNT_W'(1)); // R9
    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> $stable(cnt_miss)); // R9

endmodule

// File: tb/cac_cache_tb.sv
module cac_cache_tb;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int CNT_W  = 16;
    localparam int LINES  = 16;
    localparam int MEM_LAT = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [1:0]        rsp_kind;
    logic [DATA_W-1:0] rsp_data;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic [CNT_W-1:0]  cnt_hit, cnt_hit2, cnt_miss;

    always #4 clk = ~clk;

    cac_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
        .clk, .rst_n, .req_valid, .req_addr, .req_ready, .rsp_valid, .rsp_kind,
        .rsp_data, .mem_req_valid, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
        .cnt_hit, .cnt_hit2, .cnt_miss
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_fills = 0;
    int e_hit = 0, e_hit2 = 0, e_miss = 0;
    int last_kind = 0;
    logic [ADDR_W-1:0] cur_addr = '0;

    bit         m_v [LINES];
    bit         m_r [LINES];
    logic [12:0] m_t [LINES];

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a ^ 16'hC3A5, a};
    endfunction

    // behaviour model of slot contents; kind 1 hit, 2 second hit, 3 miss
    task automatic model_step(input logic [ADDR_W-1:0] a, output int kind, output int lat);
        int h;
        int b;
        logic [12:0] t;
        bit tv;
        logic [12:0] tt;
        h = int'(a[3:0]);
        b = h ^ 8;
        t = a[15:3];
        if (m_v[h] && m_t[h] == t) begin
            kind = 1; lat = 1;
        end else if (m_r[h]) begin
            kind = 3; lat = 2 + MEM_LAT;
            m_v[h] = 1; m_t[h] = t; m_r[h] = 0;
        end else if (m_v[b] && m_t[b] == t) begin
            kind = 2; lat = 2;
            tv = m_v[h]; tt = m_t[h];
            m_v[h] = 1; m_t[h] = t; m_r[h] = 0;
            m_v[b] = tv; m_t[b] = tt; m_r[b] = tv;
        end else begin
            kind = 3; lat = 3 + MEM_LAT;
            m_v[b] = m_v[h]; m_t[b] = m_t[h]; m_r[b] = m_v[h];
            m_v[h] = 1; m_t[h] = t; m_r[h] = 0;
        end
        if (kind == 1) e_hit++;
        else if (kind == 2) e_hit2++;
        else e_miss++;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a);
        int kind_e;
        int lat_e;
        int lat;
        bit got;
        string rq;
        model_step(a, kind_e, lat_e);
        rq = (kind_e == 1) ? "R2" : (kind_e == 2) ? "R4" : (lat_e == 2 + MEM_LAT) ? "R3" : "R6";
        while (!req_ready) @(negedge clk);
        req_addr = a; req_valid = 1'b1; cur_addr = a;
        lat = 0; got = 0;
        while (!got && lat < 40) begin
            @(negedge clk);
            lat++;
            req_valid = 1'b0;
            if (rsp_valid) got = 1;
            else if (req_ready) chk(0, "R8", "ready high while busy", 1, 0);
        end
        chk(got, rq, "response seen", got, 1);
        chk(int'(rsp_kind) == kind_e, rq, "kind", rsp_kind, kind_e);
        chk(lat == lat_e, rq, "latency", lat, lat_e);
        chk(rsp_data == mem_word(a), "R10", "data", rsp_data, mem_word(a));
        last_kind = int'(rsp_kind);
        @(negedge clk);
        if (kind_e == 2) begin
            chk(req_ready == 1'b0, "R5", "swap cycle stall", req_ready, 0);
            @(negedge clk);
        end
        chk(req_ready == 1'b1, "R8", "ready after response", req_ready, 1);
    endtask

    // next-level memory model
    initial begin
        forever begin
            @(posedge clk); #1;
            if (mem_req_valid) begin
                n_fills++;
                chk(mem_req_addr == cur_addr, "R7", "fill address", mem_req_addr, cur_addr);
                repeat (MEM_LAT) @(posedge clk);
                #1;
                mem_rsp_data = mem_word(mem_req_addr);
                mem_rsp_valid = 1'b1;
                @(posedge clk); #1;
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        int hits_run;
        void'($urandom(32'd2718));
        for (int i = 0; i < LINES; i++) begin m_v[i] = 0; m_r[i] = 0; m_t[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
        chk(cnt_hit == 0 && cnt_hit2 == 0 && cnt_miss == 0, "R1", "counters",
            cnt_hit + cnt_hit2 + cnt_miss, 0);

        // R5 a,b,c,b,c pattern: a,b share home slot 0, c lives at slot 8
        do_read(16'h0010);
        chk(last_kind == 3, "R1", "cold miss", last_kind, 3);
        do_read(16'h0020);
        do_read(16'h0018);
        hits_run = 0;
        for (int k = 0; k < 20; k++) begin
            do_read(16'h0020);
            if (last_kind == 1) hits_run++;
            do_read(16'h0018);
            if (last_kind == 1) hits_run++;
        end
        chk(hits_run == 40, "R5", "b,c all first hits", hits_run, 40);

        // R4/R5/R6/R3 directed pair on home slot 0, then a relocated slot 8
        do_read(16'h0100);
        do_read(16'h0200);
        do_read(16'h0100);
        chk(last_kind == 2, "R4", "second probe hit", last_kind, 2);
        do_read(16'h0100);
        chk(last_kind == 1, "R5", "moved home", last_kind, 1);
        do_read(16'h0200);
        chk(last_kind == 2, "R5", "displaced to buddy", last_kind, 2);
        do_read(16'h0308);
        chk(last_kind == 3, "R3", "relocated home skip", last_kind, 3);

        // seeded random conflicts across slots 0/8 and 1/9
        for (int n = 0; n < 400; n++) begin
            int t;
            int p;
            logic [ADDR_W-1:0] a;
            t = int'($urandom_range(1, 4));
            p = int'($urandom_range(0, 3));
            a = ADDR_W'((t << 4) | ((p & 1) != 0 ? 1 : 0) | ((p & 2) != 0 ? 8 : 0));
            do_read(a);
        end

        repeat (2) @(negedge clk);
        chk(int'(cnt_hit) == e_hit, "R9", "cnt_hit", cnt_hit, e_hit);
        chk(int'(cnt_hit2) == e_hit2, "R9", "cnt_hit2", cnt_hit2, e_hit2);
        chk(int'(cnt_miss) == e_miss, "R9", "cnt_miss", cnt_miss, e_miss);
        chk(n_fills == e_miss, "R7", "one fill per miss", n_fills, e_miss);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule